// File: doc/BRIEF.md
# E1 Sa6 Code Confirmation and Status Detector

This block watches the Sa6 spare bit in a received E1 frame stream. It groups the bits into 4-bit nibbles, with the first bit received as the MSB. Each nibble is sorted into one of six classes: five fixed codes plus a catch-all "other" class. A class counts as confirmed only after the same nibble value has arrived in three nibble groups in a row.

Every class has a sticky status flag. A flag stays set until software reads the status word, and the read clears all flags. When the confirmed class differs from the one confirmed before it, the block sends out a one-cycle change pulse. The pulse is meant to drive an interrupt.

Nibbles are formed in one of two ways. In free-running mode, a new nibble starts every four Sa6 strobes, counted from the first strobe once frame alignment is present. In aligned mode, each nibble starts at a CRC-4 submultiframe boundary marker. A nibble-assembly state machine handles both modes. It has three states:
- NB_IDLE: frame alignment is absent.
- NB_WAIT_MARK: aligned mode, waiting for a submultiframe marker.
- NB_COLLECT: bits are being gathered.

The transitions are:
- Any state goes to NB_IDLE whenever frame alignment is lost.
- NB_IDLE goes to NB_COLLECT in free-running mode, or to NB_WAIT_MARK in aligned mode. In aligned mode, a strobe that carries the marker takes NB_IDLE straight to NB_COLLECT.
- NB_WAIT_MARK goes to NB_COLLECT on a strobe that carries the marker.
- NB_COLLECT goes back to NB_WAIT_MARK after a complete nibble in aligned mode. In free-running mode it stays in NB_COLLECT.

The mode select should only be changed while frame alignment is absent.

Top module: `sa6_watch`

## Requirements
- R1: Bits are packed MSB first. The status word encodes the classes as follows: bit 0 = 1000, bit 1 = 1010, bit 2 = 1100, bit 3 = 1110, bit 4 = 1111, bit 5 = any other value.
- R2: A class flag is set only when the current nibble equals each of the two nibbles evaluated just before it. Two matching nibbles are not enough. The flag is visible in the cycle after the clock edge that samples the nibble's last strobe.
- R3: Any nibble value outside the five codes confirms class bit 5, but only when that same value occurs three times in a row.
- R4: Flags are sticky. A set flag stays set when later nibbles confirm another class or confirm nothing.
- R5: A read strobe clears every flag at the next edge. If a confirmation lands in the same cycle as the read, the confirmed flag stays set and all other flags are cleared.
- R6: `code_chg_irq` is high for exactly one cycle, at the same time the flag appears, when the confirmed class differs from the previously confirmed class. The first confirmation after a history flush also counts as a change. Confirming the same class again, including a different "other" value, raises no pulse.
- R7: While `frame_ok` is low, strobes are ignored and no flag or pulse is produced. The repeat history and the last confirmed class are cleared, but flags that are already set are kept.
- R8: In free-running mode (`smf_align_mode` = 0), a nibble ends on every fourth accepted strobe. Counting starts at the first strobe with `frame_ok` high, and `smf_mark` is ignored.
- R9: In aligned mode (`smf_align_mode` = 1), a strobe carrying `smf_mark` starts a new nibble, even when a nibble is partly assembled. Strobes before the first marker are ignored.
- R10: In aligned mode, nibbles are evaluated only while `mframe_ok` is high. While it is low, the history is cleared as in R7.
- R11: After reset, `stat_q` is zero and `code_chg_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sa6_bit | input | 1 | Received Sa6 bit value |
| sa6_stb | input | 1 | One-cycle strobe qualifying `sa6_bit` |
| smf_mark | input | 1 | With the strobe: this bit is the first of a submultiframe |
| frame_ok | input | 1 | Basic frame alignment present |
| mframe_ok | input | 1 | CRC-4 multiframe alignment present |
| smf_align_mode | input | 1 | 1 = nibbles aligned to submultiframe, 0 = free-running |
| stat_rd | input | 1 | Status read strobe (clear-on-read) |
| stat_q | output | 6 | Sticky class flags, encoded as in R1 |
| code_chg_irq | output | 1 | One-cycle pulse on a change of confirmed class |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:
- Two matching nibbles: a design that confirms too early sets a flag after the second nibble.
- Interrupted run: in the sequence 1000, 1000, 1010, 1000, a design that fails to restart its count sets the flag one nibble too soon.
- Two different "other" values confirmed back to back: these must not pulse the interrupt, which catches a design that compares raw values instead of classes.
- Read in the same cycle as a confirmation: a design that lets the read win loses the new flag.
- History across frame loss or multiframe loss: if the history survives, the design re-confirms at once and misses the change pulse.
- Marker mid-nibble in aligned mode: a design that ignores the marker builds shifted nibbles.
- Marker in free-running mode: a design that honours the marker here corrupts the nibble.

// File: rtl/sa6_pkg.sv
package sa6_pkg;

    localparam int SA6_NIB_W = 4;
    localparam int SA6_N_CLS = 6;

    typedef enum logic [1:0] {
        NB_IDLE      = 2'd0,
        NB_WAIT_MARK = 2'd1,
        NB_COLLECT   = 2'd2
    } nib_state_t;

    typedef enum logic [2:0] {
        CLS_8 = 3'd0,
        CLS_A = 3'd1,
        CLS_C = 3'd2,
        CLS_E = 3'd3,
        CLS_F = 3'd4,
        CLS_X = 3'd5
    } sa6_cls_t;

    function automatic sa6_cls_t sa6_classify(input logic [SA6_NIB_W-1:0] nib);
        sa6_cls_t c;
        case (nib)
            4'b1000: c = CLS_8;
            4'b1010: c = CLS_A;
            4'b1100: c = CLS_C;
            4'b1110: c = CLS_E;
            4'b1111: c = CLS_F;
            default: c = CLS_X;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sa6_nibbler.sv
module sa6_nibbler
    import sa6_pkg::*;
#(
    parameter int NIB_W = SA6_NIB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_i,
    input  logic             stb_i,
    input  logic             mark_i,
    input  logic             frm_ok_i,
    input  logic             mf_ok_i,
    input  logic             sync_i,
    output logic             nib_vld_o,
    output logic [NIB_W-1:0] nib_o,
    output logic             flush_o
);

    localparam int CW = $clog2(NIB_W) + 1;
    localparam logic [CW-1:0] LAST_POS = CW'(NIB_W - 1);

    nib_state_t       state_q, state_d;
    logic [NIB_W-2:0] sh_q;
    logic [CW-1:0]    cnt_q;
    logic             restart, cont, complete;

    // a strobe that opens a fresh nibble
    always_comb begin
        restart = 1'b0;
        if (stb_i && frm_ok_i) begin
            if (sync_i) restart = mark_i;
            else        restart = (state_q != NB_COLLECT);
        end
    end

    assign cont     = stb_i && frm_ok_i && (state_q == NB_COLLECT) && !restart;
    assign complete = cont && (cnt_q == LAST_POS);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= NB_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!frm_ok_i) begin
            state_d = NB_IDLE;
        end else begin
            unique case (state_q)
                NB_IDLE:      state_d = (sync_i && !restart) ? NB_WAIT_MARK : NB_COLLECT;
                NB_WAIT_MARK: state_d = restart ? NB_COLLECT : NB_WAIT_MARK;
                NB_COLLECT:   state_d = (complete && sync_i) ? NB_WAIT_MARK : NB_COLLECT;
                default:      state_d = NB_IDLE;
            endcase
        end
    end

    // bit shifter and position counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (!frm_ok_i || state_q == NB_IDLE && !restart) begin
            cnt_q <= '0;
        end else if (restart) begin
            sh_q  <= {sh_q[NIB_W-3:0], bit_i};
            cnt_q <= CW'(1);
        end else if (cont) begin
            sh_q  <= {sh_q[NIB_W-3:0], bit_i};
            cnt_q <= complete ? '0 : cnt_q + CW'(1);
        end
    end

    // outputs
    always_comb begin
        nib_o     = {sh_q, bit_i};
        nib_vld_o = complete && (!sync_i || mf_ok_i);
        flush_o   = !frm_ok_i || (sync_i && !mf_ok_i);
    end

    a_r8_nibble_only_when_collecting: assert property (@(posedge clk) disable iff (!rst_n)
        nib_vld_o |-> state_q == NB_COLLECT);

    a_r7_idle_after_frame_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_ok_i |=> state_q == NB_IDLE);

    a_r9_wait_needs_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == NB_WAIT_MARK && !(stb_i && mark_i)) |=> state_q != NB_COLLECT);

endmodule

// File: rtl/sa6_confirm.sv
module sa6_confirm
    import sa6_pkg::*;
#(
    parameter int NIB_W       = SA6_NIB_W,
    parameter int CONFIRM_CNT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             nib_vld_i,
    input  logic [NIB_W-1:0] nib_i,
    output logic             hit_o,
    output sa6_cls_t         hit_cls_o,
    output logic             chg_irq_o
);

    localparam int RW = $clog2(CONFIRM_CNT + 1);
    localparam logic [RW-1:0] REP_MAX  = RW'(CONFIRM_CNT);
    localparam logic [RW-1:0] REP_NEED = RW'(CONFIRM_CNT - 1);

    logic [NIB_W-1:0] last_q;
    logic [RW-1:0]    rep_q;
    logic             conf_vld_q;
    sa6_cls_t         conf_cls_q;
    logic             irq_q;
    logic             same;
    sa6_cls_t         cls_now;

    always_comb begin
        cls_now   = sa6_classify(nib_i);
        same      = (rep_q != '0) && (nib_i == last_q);
        hit_o     = nib_vld_i && !flush_i && same && (rep_q >= REP_NEED);
        hit_cls_o = cls_now;
        chg_irq_o = irq_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q     <= '0;
            rep_q      <= '0;
            conf_vld_q <= 1'b0;
            conf_cls_q <= CLS_X;
            irq_q      <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (flush_i) begin
                rep_q      <= '0;
                conf_vld_q <= 1'b0;
            end else if (nib_vld_i) begin
                last_q <= nib_i;
                if (same) rep_q <= (rep_q == REP_MAX) ? rep_q : rep_q + RW'(1);
                else      rep_q <= RW'(1);
                if (hit_o) begin
                    irq_q      <= !conf_vld_q || (conf_cls_q != cls_now);
                    conf_vld_q <= 1'b1;
                    conf_cls_q <= cls_now;
                end
            end
        end
    end

    a_r6_pulse_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        chg_irq_o |=> !chg_irq_o);

    a_r7_no_pulse_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !chg_irq_o);

    a_r6_pulse_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |=> !chg_irq_o);

endmodule

// File: rtl/sa6_sticky.sv
module sa6_sticky
    import sa6_pkg::*;
#(
    parameter int N_CLS = SA6_N_CLS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_i,
    input  logic             set_i,
    input  sa6_cls_t         cls_i,
    output logic [N_CLS-1:0] stat_o
);

    logic [N_CLS-1:0] set_vec;
    logic [N_CLS-1:0] stat_q;

    always_comb begin
        for (int i = 0; i < N_CLS; i++) begin
            set_vec[i] = set_i && (int'(cls_i) == i);
        end
        stat_o = stat_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    stat_q <= '0;
        else if (rd_i) stat_q <= set_vec;
        else           stat_q <= stat_q | set_vec;
    end

    a_r1_one_class_per_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_vec));

    a_r4_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> (stat_o & $past(stat_o)) == $past(stat_o));

    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !set_i) |=> stat_o == '0);

    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> (stat_o & $past(set_vec)) == $past(set_vec));

endmodule

// File: rtl/sa6_watch.sv
module sa6_watch
    import sa6_pkg::*;
#(
    parameter int NIB_W       = SA6_NIB_W,
    parameter int N_CLS       = SA6_N_CLS,
    parameter int CONFIRM_CNT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sa6_bit,
    input  logic             sa6_stb,
    input  logic             smf_mark,
    input  logic             frame_ok,
    input  logic             mframe_ok,
    input  logic             smf_align_mode,
    input  logic             stat_rd,
    output logic [N_CLS-1:0] stat_q,
    output logic             code_chg_irq
);

    logic             nib_vld;
    logic [NIB_W-1:0] nib;
    logic             flush;
    logic             hit;
    sa6_cls_t         hit_cls;

    sa6_nibbler #(.NIB_W(NIB_W)) u_nibbler (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_i     (sa6_bit),
        .stb_i     (sa6_stb),
        .mark_i    (smf_mark),
        .frm_ok_i  (frame_ok),
        .mf_ok_i   (mframe_ok),
        .sync_i    (smf_align_mode),
        .nib_vld_o (nib_vld),
        .nib_o     (nib),
        .flush_o   (flush)
    );

    sa6_confirm #(.NIB_W(NIB_W), .CONFIRM_CNT(CONFIRM_CNT)) u_confirm (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush),
        .nib_vld_i (nib_vld),
        .nib_i     (nib),
        .hit_o     (hit),
        .hit_cls_o (hit_cls),
        .chg_irq_o (code_chg_irq)
    );

    sa6_sticky #(.N_CLS(N_CLS)) u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_i   (stat_rd),
        .set_i  (hit),
        .cls_i  (hit_cls),
        .stat_o (stat_q)
    );

    a_r7_frame_loss_no_new_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_ok && !stat_rd) |=> stat_q == $past(stat_q));

    a_r6_pulse_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        code_chg_irq |-> stat_q != '0);

endmodule

// File: tb/sa6_watch_bench.sv
module sa6_watch_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sa6_bit, sa6_stb, smf_mark, frame_ok, mframe_ok, smf_align_mode, stat_rd;
    logic [5:0] stat_q;
    logic       code_chg_irq;
    int         n_chk  = 0;
    int         n_fail = 0;

    always #5 clk = ~clk;

    sa6_watch u_sa6_watch (
        .clk            (clk),
        .rst_n          (rst_n),
        .sa6_bit        (sa6_bit),
        .sa6_stb        (sa6_stb),
        .smf_mark       (smf_mark),
        .frame_ok       (frame_ok),
        .mframe_ok      (mframe_ok),
        .smf_align_mode (smf_align_mode),
        .stat_rd        (stat_rd),
        .stat_q         (stat_q),
        .code_chg_irq   (code_chg_irq)
    );

    // entry: {read_before, nibble, expected flags, expected pulse}
    localparam int NV = 31;
    localparam logic [11:0] VEC [NV] = '{
        {1'b0, 4'b1000, 6'b000000, 1'b0},  // R2 one match
        {1'b0, 4'b1000, 6'b000000, 1'b0},  // R2 two not enough
        {1'b0, 4'b1000, 6'b000001, 1'b1},  // R1 R2 R6 confirm 1000
        {1'b0, 4'b1000, 6'b000001, 1'b0},  // R6 same class again
        {1'b0, 4'b1010, 6'b000001, 1'b0},
        {1'b0, 4'b1010, 6'b000001, 1'b0},
        {1'b0, 4'b1010, 6'b000011, 1'b1},  // R4 sticky + R1 bit1
        {1'b1, 4'b1100, 6'b000000, 1'b0},  // R5 read clears
        {1'b0, 4'b1100, 6'b000000, 1'b0},
        {1'b0, 4'b1100, 6'b000100, 1'b1},  // R1 bit2
        {1'b1, 4'b1110, 6'b000000, 1'b0},
        {1'b0, 4'b1110, 6'b000000, 1'b0},
        {1'b0, 4'b1110, 6'b001000, 1'b1},  // R1 bit3
        {1'b1, 4'b1111, 6'b000000, 1'b0},
        {1'b0, 4'b1111, 6'b000000, 1'b0},
        {1'b0, 4'b1111, 6'b010000, 1'b1},  // R1 bit4
        {1'b1, 4'b0011, 6'b000000, 1'b0},
        {1'b0, 4'b0011, 6'b000000, 1'b0},
        {1'b0, 4'b0011, 6'b100000, 1'b1},  // R3 other class
        {1'b0, 4'b0101, 6'b100000, 1'b0},
        {1'b0, 4'b0101, 6'b100000, 1'b0},
        {1'b0, 4'b0101, 6'b100000, 1'b0},  // R3 R6 other again, no pulse
        {1'b1, 4'b1111, 6'b000000, 1'b0},
        {1'b0, 4'b1111, 6'b000000, 1'b0},
        {1'b0, 4'b1111, 6'b010000, 1'b1},
        {1'b1, 4'b1000, 6'b000000, 1'b0},
        {1'b0, 4'b1000, 6'b000000, 1'b0},
        {1'b0, 4'b1010, 6'b000000, 1'b0},  // R2 run broken
        {1'b0, 4'b1000, 6'b000000, 1'b0},
        {1'b0, 4'b1000, 6'b000000, 1'b0},
        {1'b0, 4'b1000, 6'b000001, 1'b1}   // R2 R8 free-running nibbles
    };

    task automatic chk(input string req, input logic [5:0] es, input logic ei);
        n_chk++;
        if (stat_q !== es || code_chg_irq !== ei) begin
            n_fail++;
            $display("FAIL %s: stat=%b irq=%b expected stat=%b irq=%b",
                     req, stat_q, code_chg_irq, es, ei);
        end
    endtask

    task automatic strobe(input logic b, input logic mk, input logic rd);
        sa6_stb  = 1'b1;
        sa6_bit  = b;
        smf_mark = mk;
        stat_rd  = rd;
        @(negedge clk);
        sa6_stb  = 1'b0;
        smf_mark = 1'b0;
        stat_rd  = 1'b0;
    endtask

    // mpos: bit index carrying the marker (4 = none)
    task automatic send_nib(input logic [3:0] n, input int mpos, input logic rd_last);
        for (int i = 0; i < 4; i++) strobe(n[3-i], mpos == i, rd_last && i == 3);
    endtask

    task automatic read_pulse();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R11 watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; sa6_bit = 1'b0; sa6_stb = 1'b0; smf_mark = 1'b0;
        frame_ok = 1'b0; mframe_ok = 1'b0; smf_align_mode = 1'b0; stat_rd = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 reset", 6'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        frame_ok = 1'b1;

        for (int k = 0; k < NV; k++) begin
            if (VEC[k][11]) read_pulse();
            send_nib(VEC[k][10:7], 4, 1'b0);
            chk($sformatf("R1-table entry %0d (R2 R3 R4 R5 R6 R8)", k), VEC[k][6:1], VEC[k][0]);
        end

        // R5: read in the same cycle as a confirmation
        send_nib(4'b1111, 4, 1'b0);
        send_nib(4'b1111, 4, 1'b0);
        send_nib(4'b1111, 4, 1'b0);
        chk("R4 before read-collision", 6'b010001, 1'b1);
        send_nib(4'b1111, 4, 1'b1);
        chk("R5 detection beats read", 6'b010000, 1'b0);

        // R7: frame loss
        read_pulse();
        chk("R5 read clears", 6'b0, 1'b0);
        frame_ok = 1'b0;
        send_nib(4'b1000, 4, 1'b0);
        send_nib(4'b1000, 4, 1'b0);
        send_nib(4'b1000, 4, 1'b0);
        chk("R7 strobes ignored while unaligned", 6'b0, 1'b0);
        frame_ok = 1'b1;
        send_nib(4'b1111, 4, 1'b0);
        send_nib(4'b1111, 4, 1'b0);
        chk("R7 history cleared", 6'b0, 1'b0);
        send_nib(4'b1111, 1, 1'b0);
        chk("R7 R8 reconfirm with pulse, marker ignored", 6'b010000, 1'b1);

        // R9: aligned mode
        frame_ok = 1'b0;
        @(negedge clk);
        smf_align_mode = 1'b1;
        mframe_ok = 1'b1;
        frame_ok = 1'b1;
        @(negedge clk);
        read_pulse();
        chk("R9 aligned start", 6'b0, 1'b0);
        strobe(1'b0, 1'b0, 1'b0);
        strobe(1'b1, 1'b0, 1'b0);
        send_nib(4'b1100, 0, 1'b0);
        chk("R9 bits before marker dropped", 6'b0, 1'b0);
        send_nib(4'b1100, 0, 1'b0);
        send_nib(4'b1100, 0, 1'b0);
        chk("R9 aligned confirm", 6'b000100, 1'b1);
        read_pulse();
        strobe(1'b1, 1'b1, 1'b0);
        strobe(1'b1, 1'b0, 1'b0);
        send_nib(4'b1010, 0, 1'b0);
        send_nib(4'b1010, 0, 1'b0);
        chk("R9 two after realign", 6'b0, 1'b0);
        send_nib(4'b1010, 0, 1'b0);
        chk("R9 marker realigns mid-nibble", 6'b000010, 1'b1);

        // R10: multiframe loss
        read_pulse();
        mframe_ok = 1'b0;
        send_nib(4'b1010, 0, 1'b0);
        send_nib(4'b1010, 0, 1'b0);
        send_nib(4'b1010, 0, 1'b0);
        chk("R10 no evaluation without multiframe", 6'b0, 1'b0);
        mframe_ok = 1'b1;
        send_nib(4'b1010, 0, 1'b0);
        send_nib(4'b1010, 0, 1'b0);
        chk("R10 history cleared", 6'b0, 1'b0);
        send_nib(4'b1010, 0, 1'b0);
        chk("R10 reconfirm with pulse", 6'b000010, 1'b1);
        @(negedge clk);
        chk("R6 pulse lasts one cycle", 6'b000010, 1'b0);

        summary();
        $finish;
    end

endmodule